// File: doc/BRIEF.md
# Two-Wire Bus Unstick Sequencer

This block sits on the host side of a two-wire serial bus (SCL clock, SDA data, both open drain). It frees the bus after a protocol interruption or reset has left a target holding SDA low. When software or a higher-level controller raises a request, the sequencer drives SCL through up to a fixed number of clock pulses and keeps its own SDA driver off. After each SCL high phase it checks whether SDA has come back high. When it sees SDA high it stops clocking at once. It then puts a start condition on the bus, follows it with a stop condition, and signals completion.

If SDA is still low after the last permitted pulse, the sequencer gives up. It raises a failure flag and leaves both lines released. The lengths of the SCL low and high phases are parameters counted in system clock cycles. Each output pin is a drive-low enable for an open-drain pad. The bus levels come back in through the input pins, and SDA passes through a synchronizer before it is sampled.

Top module: `bus_unstick`

## Requirements
- R1: After reset both drive enables (`scl_drive_o`, `sda_drive_o`) are 0, and `busy_o`, `done_o` and `fail_o` are 0.
- R2: A request accepted while idle makes `scl_drive_o` go to 1 and `busy_o` go to 1 on the next clock edge. Each recovery pulse holds `scl_drive_o` at 1 for exactly `LOW_CYC` cycles and then at 0 for `HIGH_CYC` cycles. `sda_drive_o` stays 0 throughout the pulses.
- R3: SDA is sampled through a `SYNC_STAGES` flip-flop synchronizer in the last cycle of each SCL high phase. The first high sample ends the clocking, so the number of pulses equals the index of the first pulse that sees SDA released. At least one pulse is always issued.
- R4: No more than `MAX_PULSES` (default 9) recovery pulses are issued per request.
- R5: Once SDA is sampled high, `sda_drive_o` rises while `scl_drive_o` is 0, which forms a start condition. It holds for `HIGH_CYC` cycles.
- R6: After the start, SCL is driven low for `LOW_CYC` cycles and then released for `HIGH_CYC` cycles, with SDA still driven. SDA is then released while SCL is released, which forms a stop condition. Both lines stay released for `HIGH_CYC` cycles, after which `done_o` pulses for exactly one cycle and `busy_o` falls in the same cycle.
- R7: `sda_drive_o` changes only while `scl_drive_o` is 0. A successful sequence has exactly one SDA drive rise and one SDA drive fall.
- R8: If SDA is still low at the end of the high phase of pulse `MAX_PULSES`, `fail_o` goes to 1, both lines are released, `busy_o` falls and `done_o` stays 0. `fail_o` holds until the next accepted request clears it.
- R9: A request that arrives while `busy_o` is 1 is ignored. The pulse count and the single `done_o` of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a recovery sequence (sampled while idle) |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_drive_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a recovery sequence succeeds |
| fail_o | output | 1 | SDA never released; held until the next request |

## Verification
The hardest conditions to reach are the two ends of the pulse budget. In one, the stuck target lets go in the high phase of exactly the last allowed pulse. In the other, it lets go one pulse too late. The bench models the target as a wired-AND partner that holds SDA low for a programmed number of completed SCL high phases. It counts the SCL drive rises it observes, so any release point from "already free" to "never" can be placed exactly. The same monitor measures every SCL low run and records the SCL level at each SDA drive edge. Start, stop and data-timing violations therefore appear at the ports without looking inside the block.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STA_HOLD,
    ST_STP_LO,
    ST_STP_HI,
    ST_STP_REL
  } ubr_state_e;

  function automatic int unsigned ubr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ubr_sync.sv
module ubr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;  // idle bus reads high
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ubr_timer.sv
module ubr_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // R2
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ubr_ctrl.sv
module ubr_ctrl
  import ubr_pkg::*;
#(
  parameter int unsigned LOW_CYC    = 6,
  parameter int unsigned HIGH_CYC   = 5,
  parameter int unsigned MAX_PULSES = 9,
  parameter int unsigned CW         = 4,
  localparam int unsigned PW        = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          sda_s_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          scl_drive_o,
  output logic          sda_drive_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam logic [CW-1:0] LEN_LO = CW'(LOW_CYC);
  localparam logic [CW-1:0] LEN_HI = CW'(HIGH_CYC);
  localparam logic [PW-1:0] LAST  = PW'(MAX_PULSES - 1);

  ubr_state_e state_q, state_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic done_q, fail_q, done_d, fail_d;

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    len_o   = LEN_HI;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_CLK_LO; load_o = 1'b1; len_o = LEN_LO;
        pulse_d = '0; fail_d = 1'b0;
      end
      ST_CLK_LO: if (expire_i) begin
        state_d = ST_CLK_HI; load_o = 1'b1; len_o = LEN_HI;
      end
      ST_CLK_HI: if (expire_i) begin
        if (sda_s_i) begin
          state_d = ST_STA_HOLD; load_o = 1'b1; len_o = LEN_HI;
        end else if (pulse_q == LAST) begin
          state_d = ST_IDLE; fail_d = 1'b1;
        end else begin
          state_d = ST_CLK_LO; load_o = 1'b1; len_o = LEN_LO;
          pulse_d = pulse_q + 1'b1;
        end
      end
      ST_STA_HOLD: if (expire_i) begin
        state_d = ST_STP_LO; load_o = 1'b1; len_o = LEN_LO;
      end
      ST_STP_LO: if (expire_i) begin
        state_d = ST_STP_HI; load_o = 1'b1; len_o = LEN_HI;
      end
      ST_STP_HI: if (expire_i) begin
        state_d = ST_STP_REL; load_o = 1'b1; len_o = LEN_HI;
      end
      ST_STP_REL: if (expire_i) begin
        state_d = ST_IDLE; done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign scl_drive_o = (state_q == ST_CLK_LO) || (state_q == ST_STP_LO);
  assign sda_drive_o = (state_q == ST_STA_HOLD) || (state_q == ST_STP_LO) ||
                       (state_q == ST_STP_HI);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  // R4
  pulse_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q < PW'(MAX_PULSES));

  // R7
  sda_edge_scl_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_drive_o != $past(sda_drive_o)) |-> !scl_drive_o);

  // R8
  done_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fail_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !expire_i) |=> busy_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !scl_drive_o && !sda_drive_o));
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
  import ubr_pkg::*;
#(
  parameter int unsigned LOW_CYC     = 6,
  parameter int unsigned HIGH_CYC    = 5,
  parameter int unsigned MAX_PULSES  = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_o,
  output logic sda_drive_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned CW = $clog2(ubr_max(LOW_CYC, HIGH_CYC) + 1);

  logic          sda_s, expire, load;
  logic [CW-1:0] len;
  logic          scl_unused;

  assign scl_unused = scl_i;  // level observed by bus, not needed for timing

  ubr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s)
  );

  ubr_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .expire_o(expire)
  );

  ubr_ctrl #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .MAX_PULSES(MAX_PULSES), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .sda_s_i(sda_s), .expire_i(expire),
    .load_o(load), .len_o(len),
    .scl_drive_o, .sda_drive_o, .busy_o, .done_o, .fail_o
  );
endmodule

// File: tb/sim_bus_unstick.sv
module sim_bus_unstick;
  localparam int LOW = 6;
  localparam int HIGH = 5;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic scl_drv, sda_drv, busy, done, fail;
  logic tgt_hold = 1'b0;
  wire  scl_bus = !scl_drv;
  wire  sda_bus = !(sda_drv || tgt_hold);

  always #10 clk = ~clk;  // 50 MHz

  bus_unstick #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_o(scl_drv), .sda_drive_o(sda_drv), .busy_o(busy),
    .done_o(done), .fail_o(fail)
  );

  int n_chk = 0, n_bad = 0;
  int rel_after = 0;
  int scl_rises, sda_rise_ok, sda_fall_ok, sda_bad, low_bad, done_cnt, run_len, first_hi;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    scl_rises = 0; sda_rise_ok = 0; sda_fall_ok = 0; sda_bad = 0;
    low_bad = 0; done_cnt = 0; run_len = 0; first_hi = -1;
  endtask

  // port monitor and stuck-target model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (scl_drv != prev_scl) begin
        if (prev_scl && run_len != LOW) low_bad++;
        if (!prev_scl && scl_rises > 0 && first_hi < 0) first_hi = run_len;
        if (scl_drv) begin
          scl_rises++;
          if (tgt_hold && scl_rises == rel_after + 1) tgt_hold = 1'b0;
        end
        run_len = 1;
      end else run_len++;
      if (sda_drv != prev_sda) begin
        if (scl_drv) sda_bad++;
        else if (sda_drv) sda_rise_ok++;
        else sda_fall_ok++;
      end
      prev_scl = scl_drv;
      prev_sda = sda_drv;
    end
  end

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_idle(output bit hung);
    int guard = 0;
    hung = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    if (busy) hung = 1;
    repeat (2) @(negedge clk);
  endtask

  // K = completed SCL high phases the target keeps SDA low for
  task automatic run_case(input int k, input bit inject_req);
    bit hung;
    int exp_p;
    bit exp_ok;
    clr_mon();
    rel_after = k;
    tgt_hold = (k > 0);
    exp_ok = (k + 1 <= MAXP);
    exp_p = exp_ok ? k + 1 : MAXP;
    pulse_req();
    chk(busy && scl_drv, "R2", int'(busy), 1);
    if (inject_req) begin
      repeat (LOW + 3) @(negedge clk);
      pulse_req();  // R9: must be ignored
    end
    wait_idle(hung);
    chk(!hung, "R2", int'(hung), 0);
    chk(scl_rises == exp_p + (exp_ok ? 1 : 0), exp_ok ? "R3" : "R4",
        scl_rises, exp_p + (exp_ok ? 1 : 0));
    chk(low_bad == 0, "R2", low_bad, 0);
    chk(sda_bad == 0, "R7", sda_bad, 0);
    chk(!scl_drv && !sda_drv, exp_ok ? "R6" : "R8", int'(scl_drv) + int'(sda_drv), 0);
    if (exp_ok) begin
      chk(sda_rise_ok == 1, "R5", sda_rise_ok, 1);
      chk(sda_fall_ok == 1, "R6", sda_fall_ok, 1);
      chk(done_cnt == 1, inject_req ? "R9" : "R6", done_cnt, 1);
      chk(!fail, "R8", int'(fail), 0);
    end else begin
      chk(sda_rise_ok == 0, "R8", sda_rise_ok, 0);
      chk(done_cnt == 0, "R8", done_cnt, 0);
      chk(fail, "R8", int'(fail), 1);
    end
    if (k >= 1) chk(first_hi == HIGH, "R2", first_hi, HIGH);
    tgt_hold = 1'b0;
  endtask

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    // R1
    chk(!scl_drv && !sda_drv && !busy && !done && !fail, "R1",
        int'(scl_drv) + int'(sda_drv) + int'(busy) + int'(done) + int'(fail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(0, 1'b0);   // bus already free: one pulse
    run_case(3, 1'b0);
    run_case(8, 1'b0);   // released on last allowed pulse
    run_case(9, 1'b0);   // one pulse too late: fail
    run_case(2, 1'b0);   // R8: fail cleared by new request
    run_case(20, 1'b0);
    run_case(4, 1'b1);   // R9: request while busy
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule